// File: doc/BRIEF.md
# Supply-Supervised Power Mode Sequencer

This block sequences the operating modes of a system basis controller. A prescaler turns the core clock into millisecond ticks, and the sequencer times reset windows and watchdog windows in those ticks. It watches an undervoltage flag on the main logic supply, a battery-fail flag that software clears with a strobe, a configured default low-power mode, a watchdog-refresh strobe and a wake-up event. From these it drives the mode code, the reset and interrupt pin levels, the watchdog pin level and the enables of the main and auxiliary regulators.

After power-on the block holds reset for a short window. It then waits in a normal-request mode for a first watchdog write. If no write arrives in time, the block asserts reset again, and it keeps doing so until a write comes. A supply undervoltage normally leads to the same short reset and retry path. When sleep is the configured default and the battery-fail flag has been cleared, the block instead holds a long reset window and then enters sleep with both regulators off. A wake-up event in sleep brings the main regulator back up through a short reset window.

Top module: `pwr_mode_seq`

## Requirements
- R1: After rst_ni is released the mode is reset (code 0) with the battery-fail flag set. After RST_SHORT_MS ms the mode becomes normal-request (code 1).
- R2: The long path applies when uv_i is seen in normal-request or normal mode, lp_sleep_i is 1 (sleep default) and the battery-fail flag has been cleared. The block then holds reset for RST_LONG_MS ms and enters sleep (code 3) with main_en_o and aux_en_o both 0.
- R3: In reset mode rst_no and int_no are 0. In every other mode both are 1.
- R4: wd_o is 1 in reset, normal-request and normal mode, and 0 in sleep.
- R5: In normal-request mode without a watchdog write, the block enters reset after NREQ_MS ms. It returns to normal-request after RST_SHORT_MS ms, and the cycle repeats.
- R6: A wd_wr_i pulse in normal-request mode moves the block to normal mode (code 2) on the next clock. In normal mode each wd_wr_i pulse restarts a WDG_MS ms window. Expiry of that window enters the short reset.
- R7: rst_no rises only at the end of a reset window.
- R8: wake_i in sleep enters reset on the next clock with main_en_o at 1. The reset is followed by normal-request after RST_SHORT_MS ms.
- R9: If the battery-fail flag is still set, or lp_sleep_i is 0 (stop default), uv_i leads to the short reset followed by normal-request.
- R10: One ms is TICK_DIV clocks. A window of N ms ends on the N*TICK_DIV-th rising edge after the mode entry or after the watchdog restart.
- R11: The mode codes are reset=0, normal-request=1, normal=2, sleep=3. main_en_o is 1 in every mode except sleep. aux_en_o is 1 only in normal-request and normal mode.
- R12: uv_i and wd_wr_i have no effect in reset or sleep mode. wake_i has no effect outside sleep mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| uv_i | input | 1 | Main supply undervoltage flag |
| batfail_clr_i | input | 1 | Strobe that clears the battery-fail flag |
| lp_sleep_i | input | 1 | Default low-power mode: 1 sleep, 0 stop |
| wd_wr_i | input | 1 | Watchdog refresh strobe |
| wake_i | input | 1 | Wake-up event |
| mode_o | output | 2 | Current mode code |
| rst_no | output | 1 | Reset pin level, active low |
| int_no | output | 1 | Interrupt pin level, active low |
| wd_o | output | 1 | Watchdog pin level |
| main_en_o | output | 1 | Main regulator enable |
| aux_en_o | output | 1 | Auxiliary regulator enable |

## Verification
Every output is decoded from the mode register, so an event captured on a rising edge shows at the outputs right after that edge. Each window of N ms ends exactly on the N*TICK_DIV-th rising edge after the entry. The bench drives its inputs on falling edges and steps its behavioural model on rising edges. It compares all outputs on every falling edge. Its scenario checks count falling edges from the entry edge and sample one edge before and one edge after each expected expiry.

// File: rtl/pms_pkg.sv
package pms_pkg;
  typedef enum logic [1:0] {
    MODE_RESET  = 2'd0,
    MODE_NREQ   = 2'd1,
    MODE_NORMAL = 2'd2,
    MODE_SLEEP  = 2'd3
  } pms_mode_e;
endpackage

// File: rtl/pms_prescaler.sv
module pms_prescaler #(
  parameter int DIV = 50000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic tick_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  logic [CW-1:0] cnt_q;

  assign tick_o = (cnt_q == CW'(DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + CW'(1);
  end
endmodule

// File: rtl/pms_window_timer.sv
module pms_window_timer #(
  parameter int MAX_MS = 350,
  localparam int W = $clog2(MAX_MS + 1)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         tick_i,
  input  logic [W-1:0] len_i,
  output logic         expire_o
);
  logic [W-1:0] ms_q;

  assign expire_o = tick_i && (ms_q == len_i - W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ms_q <= '0;
    else if (clr_i)  ms_q <= '0;
    else if (tick_i) ms_q <= ms_q + W'(1);
  end
endmodule

// File: rtl/pms_fsm.sv
module pms_fsm
  import pms_pkg::*;
#(
  parameter int RST_SHORT_MS = 20,
  parameter int RST_LONG_MS  = 100,
  parameter int NREQ_MS      = 350,
  parameter int WDG_MS       = 100,
  parameter int LW           = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          uv_i,
  input  logic          batfail_clr_i,
  input  logic          lp_sleep_i,
  input  logic          wd_wr_i,
  input  logic          wake_i,
  input  logic          expire_i,
  output pms_mode_e     mode_o,
  output logic          restart_o,
  output logic [LW-1:0] len_o
);
  pms_mode_e mode_q, mode_d;
  logic      long_q, long_d;   // current reset window leads to sleep
  logic      bf_q;

  always_comb begin
    mode_d    = mode_q;
    long_d    = long_q;
    restart_o = 1'b0;
    unique case (mode_q)
      MODE_RESET: if (expire_i) begin
        mode_d    = long_q ? MODE_SLEEP : MODE_NREQ;
        long_d    = 1'b0;
        restart_o = 1'b1;
      end
      MODE_NREQ, MODE_NORMAL: begin
        if (uv_i) begin
          mode_d    = MODE_RESET;
          long_d    = lp_sleep_i && !bf_q;
          restart_o = 1'b1;
        end else if (wd_wr_i) begin
          mode_d    = MODE_NORMAL;
          restart_o = 1'b1;
        end else if (expire_i) begin
          mode_d    = MODE_RESET;
          long_d    = 1'b0;
          restart_o = 1'b1;
        end
      end
      MODE_SLEEP: if (wake_i) begin
        mode_d    = MODE_RESET;
        long_d    = 1'b0;
        restart_o = 1'b1;
      end
      default: ;
    endcase
  end

  always_comb begin
    unique case (mode_q)
      MODE_RESET:  len_o = long_q ? LW'(RST_LONG_MS) : LW'(RST_SHORT_MS);
      MODE_NREQ:   len_o = LW'(NREQ_MS);
      default:     len_o = LW'(WDG_MS);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_RESET;
      long_q <= 1'b0;
      bf_q   <= 1'b1;
    end else begin
      mode_q <= mode_d;
      long_q <= long_d;
      if (batfail_clr_i) bf_q <= 1'b0;
    end
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
  import pms_pkg::*;
#(
  parameter int TICK_DIV     = 50000,
  parameter int RST_SHORT_MS = 20,
  parameter int RST_LONG_MS  = 100,
  parameter int NREQ_MS      = 350,
  parameter int WDG_MS       = 100
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       uv_i,
  input  logic       batfail_clr_i,
  input  logic       lp_sleep_i,
  input  logic       wd_wr_i,
  input  logic       wake_i,
  output logic [1:0] mode_o,
  output logic       rst_no,
  output logic       int_no,
  output logic       wd_o,
  output logic       main_en_o,
  output logic       aux_en_o
);
  localparam int M1     = (RST_SHORT_MS > RST_LONG_MS) ? RST_SHORT_MS : RST_LONG_MS;
  localparam int M2     = (NREQ_MS > WDG_MS) ? NREQ_MS : WDG_MS;
  localparam int MAX_MS = (M1 > M2) ? M1 : M2;
  localparam int LW     = $clog2(MAX_MS + 1);

  logic          tick, expire, restart;
  logic [LW-1:0] len;
  pms_mode_e     mode;

  pms_prescaler #(.DIV(TICK_DIV)) u_presc (
    .clk_i, .rst_ni, .clr_i(restart), .tick_o(tick)
  );

  pms_window_timer #(.MAX_MS(MAX_MS)) u_timer (
    .clk_i, .rst_ni, .clr_i(restart), .tick_i(tick), .len_i(len), .expire_o(expire)
  );

  pms_fsm #(
    .RST_SHORT_MS(RST_SHORT_MS), .RST_LONG_MS(RST_LONG_MS),
    .NREQ_MS(NREQ_MS), .WDG_MS(WDG_MS), .LW(LW)
  ) u_fsm (
    .clk_i, .rst_ni, .uv_i, .batfail_clr_i, .lp_sleep_i, .wd_wr_i, .wake_i,
    .expire_i(expire), .mode_o(mode), .restart_o(restart), .len_o(len)
  );

  assign mode_o    = mode;
  assign rst_no    = (mode != MODE_RESET);
  assign int_no    = (mode != MODE_RESET);
  assign wd_o      = (mode != MODE_SLEEP);
  assign main_en_o = (mode != MODE_SLEEP);
  assign aux_en_o  = (mode == MODE_NREQ) || (mode == MODE_NORMAL);
endmodule

// File: rtl/pms_checker.sv
module pms_checker
  import pms_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       uv_i,
  input logic       wd_wr_i,
  input logic       wake_i,
  input logic [1:0] mode_o,
  input logic       rst_no,
  input logic       int_no,
  input logic       wd_o,
  input logic       main_en_o,
  input logic       aux_en_o
);
  assert_reset_pins_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == MODE_RESET) |-> (!rst_no && !int_no));

  assert_wd_high_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == MODE_RESET) |-> wd_o);

  assert_sleep_off_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == MODE_SLEEP) |-> (!main_en_o && !aux_en_o));

  assert_first_write_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == MODE_NREQ && wd_wr_i && !uv_i) |=> (mode_o == MODE_NORMAL));

  assert_wake_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == MODE_SLEEP && wake_i) |=> (mode_o == MODE_RESET && main_en_o));

  assert_release_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_no) |-> ($past(mode_o) == MODE_RESET));

  assert_sleep_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == MODE_SLEEP && !wake_i) |=> (mode_o == MODE_SLEEP));
endmodule

bind pwr_mode_seq pms_checker u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .uv_i(uv_i), .wd_wr_i(wd_wr_i), .wake_i(wake_i),
  .mode_o(mode_o), .rst_no(rst_no), .int_no(int_no), .wd_o(wd_o),
  .main_en_o(main_en_o), .aux_en_o(aux_en_o)
);

// File: tb/pwr_mode_seq_test.sv
module pwr_mode_seq_test;
  localparam int TD = 4, SHORT = 20, LONG = 100, NREQ = 350, WDG = 50;

  logic clk = 0, rst_ni = 0;
  logic uv = 0, bclr = 0, lps = 0, wdw = 0, wake = 0;
  logic [1:0] mode;
  logic rst_n, int_n, wd, men, aen;
  int checks = 0, errors = 0;
  bit run = 0;

  always #10 clk = ~clk;

  pwr_mode_seq #(.TICK_DIV(TD), .RST_SHORT_MS(SHORT), .RST_LONG_MS(LONG),
                 .NREQ_MS(NREQ), .WDG_MS(WDG)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .uv_i(uv), .batfail_clr_i(bclr), .lp_sleep_i(lps),
    .wd_wr_i(wdw), .wake_i(wake), .mode_o(mode), .rst_no(rst_n), .int_no(int_n),
    .wd_o(wd), .main_en_o(men), .aux_en_o(aen));

  // behavioural model: mode, cycles spent in window, flag, window kind
  int m_mode = 0, m_el = 0, m_len = SHORT;
  bit m_bf = 1;
  always @(posedge clk) begin
    if (!rst_ni) begin
      m_mode = 0; m_el = 0; m_bf = 1; m_len = SHORT;
    end else begin
      bit exp_now;
      exp_now = (m_el == m_len * TD - 1);
      m_el++;
      case (m_mode)
        0: if (exp_now) begin m_mode = (m_len == LONG) ? 3 : 1; m_el = 0;
                              m_len = (m_mode == 1) ? NREQ : 0; end
        1, 2: if (uv) begin m_len = (lps && !m_bf) ? LONG : SHORT; m_mode = 0; m_el = 0; end
              else if (wdw) begin m_mode = 2; m_len = WDG; m_el = 0; end
              else if (exp_now) begin m_mode = 0; m_len = SHORT; m_el = 0; end
        3: if (wake) begin m_mode = 0; m_len = SHORT; m_el = 0; end
        default: ;
      endcase
      if (bclr) m_bf = 0;
    end
  end

  task automatic chk(input string tag, input int act, input int exp_v);
    checks++;
    if (act != exp_v) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp_v, $time);
    end
  endtask

  always @(negedge clk) if (run) begin
    chk("R11 mode_o", mode, m_mode);
    chk("R3 rst_no", rst_n, m_mode != 0);
    chk("R3 int_no", int_n, m_mode != 0);
    chk("R4 wd_o", wd, m_mode != 3);
    chk("R11 main_en_o", men, m_mode != 3);
    chk("R11 aux_en_o", aen, m_mode == 1 || m_mode == 2);
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait_n(3);
    rst_ni = 1; run = 1;
    // R1, R3, R4: reset state
    chk("R1 mode after reset", mode, 0);
    chk("R3 rst_no after reset", rst_n, 0);
    chk("R4 wd_o in reset", wd, 1);
    wait_n(SHORT*TD - 1);
    chk("R7 rst_no held before window end", rst_n, 0);
    wait_n(1);
    chk("R1 normal-request after short window", mode, 1);
    chk("R10 rst_no released on exact edge", rst_n, 1);
    // R5: repeating reset without watchdog write
    wait_n(NREQ*TD - 1);
    chk("R5 still normal-request", mode, 1);
    wait_n(1);
    chk("R5 reset on timeout", mode, 0);
    wait_n(SHORT*TD);
    chk("R5 back to normal-request", mode, 1);
    // R6: first write and refresh
    wdw = 1; wait_n(1); wdw = 0;
    chk("R6 normal after write", mode, 2);
    wait_n(150);
    wdw = 1; wait_n(1); wdw = 0;
    wait_n(WDG*TD - 1);
    chk("R6 refresh keeps normal", mode, 2);
    wait_n(1);
    chk("R6 reset on watchdog expiry", mode, 0);
    wait_n(SHORT*TD);
    chk("R6 normal-request after reset", mode, 1);
    // R9: undervoltage with battery-fail still set
    lps = 1;
    uv = 1; wait_n(1); uv = 0;
    chk("R9 reset on uv", mode, 0);
    wait_n(SHORT*TD);
    chk("R9 short path to normal-request", mode, 1);
    // R2: sleep path, uv held through reset (R12)
    bclr = 1; wait_n(1); bclr = 0;
    uv = 1; wait_n(1);
    chk("R2 reset on uv", mode, 0);
    wait_n(LONG*TD - 1);
    chk("R12 uv held in reset ignored", mode, 0);
    wait_n(1);
    chk("R2 sleep after long window", mode, 3);
    chk("R2 main_en_o off", men, 0);
    chk("R2 aux_en_o off", aen, 0);
    chk("R4 wd_o low in sleep", wd, 0);
    uv = 0;
    // R12: ignored in sleep
    wdw = 1; wait_n(1); wdw = 0;
    chk("R12 wd_wr ignored in sleep", mode, 3);
    uv = 1; wait_n(1); uv = 0;
    chk("R12 uv ignored in sleep", mode, 3);
    // R8: wake-up
    wake = 1; wait_n(1); wake = 0;
    chk("R8 reset on wake", mode, 0);
    chk("R8 main_en_o on", men, 1);
    wait_n(SHORT*TD);
    chk("R8 normal-request after wake reset", mode, 1);
    wake = 1; wait_n(1); wake = 0;
    chk("R12 wake ignored outside sleep", mode, 1);
    // R9: stop default takes short path
    lps = 0;
    uv = 1; wait_n(1); uv = 0;
    chk("R9 reset on uv, stop default", mode, 0);
    wait_n(SHORT*TD);
    chk("R9 normal-request, stop default", mode, 1);
    wait_n(2);
    run = 0;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule